// File: doc/BRIEF.md
# Per-Bank Refresh Scheduler

This block decides when, and on which bank, a DRAM controller should issue a single-bank refresh for one rank. A free-running cycle counter is compared with a trigger time that starts one refresh interval after reset. When the trigger is reached, the block picks a bank from the set of banks not yet refreshed in the current round. It prefers a bank whose traffic queue is idle. It then asks the controller for a precharge, if that bank has an open row, or for a per-bank refresh. The request stays on the outputs until the controller reports through the feedback input which command it actually sent.

A signed credit counter lets the schedule drift. When every candidate bank is busy, a refresh is postponed and the counter rises. When the counter reaches the postpone limit, the refresh is forced: the chosen bank is flagged as blocked, so the controller holds off normal traffic to it. After a refresh issues on schedule, the block pulls in further refreshes to idle banks back to back, and the counter falls towards the pull-in limit. Power-down and self-refresh transitions reported on the feedback input put the block to sleep and wake it again.

Top module: `refsched_top`

## Requirements
- R1: Out of reset, `req_cmd` is 00, `bank_blocked` is all zero and `pd_wake_req` is 0. The first refresh request appears REF_INTERVAL+1 cycles after reset is released, counting the first rising edge without reset as cycle 1.
- R2: On the cycle after the counter reaches the trigger time, `pd_wake_req` pulses high for exactly one cycle. It pulses even while the block sleeps in power-down.
- R3: `req_cmd` encodes 00 none, 01 precharge, 10 per-bank refresh. The target is the lowest-indexed idle bank in the remaining set. The request is a precharge when `bank_active` of the target is 1, and a refresh otherwise.
- R4: A per-bank refresh reported on `fb_cmd` removes `req_bank` from the remaining set. When the set becomes empty, it is refilled with all banks. The next round therefore resumes at the lowest bank not yet refreshed.
- R5: In the regular state, when no remaining bank is idle and the credit is below MAX_POSTPONE*N_BANKS, no request is made. The credit rises by one and the trigger moves one interval later.
- R6: When the credit equals MAX_POSTPONE*N_BANKS, the refresh is forced on the chosen bank, or on the lowest remaining bank if none is idle. An open row gets a precharge first. The refresh request sets that bank's one-hot bit in `bank_blocked`, and the bit stays set until the refresh is reported issued.
- R7: A refresh issued in the regular state moves the block to the pulled-in state. It then requests refreshes to idle remaining banks back to back, and each one issued lowers the credit by one. When the credit reaches -(MAX_PULLIN*N_BANKS), the block returns to regular and the trigger moves one interval later.
- R8: In the pulled-in state, when no remaining bank is idle, the block returns to regular and the trigger moves one interval later.
- R9: When the counter reaches the trigger time plus one full interval, the trigger moves one interval later and the state is forced back to regular, even while a request is outstanding.
- R10: A request holds `req_cmd` and `req_bank` stable until `fb_cmd` reports a precharge (001) or a per-bank refresh (010). That report clears the request on the same edge.
- R11: `fb_cmd` 100 (power-down entry) clears any request and stops new ones. `fb_cmd` 101 (power-down exit) resumes scheduling with the trigger unchanged.
- R12: `fb_cmd` 110 (self-refresh entry) puts the block to sleep and parks the trigger at the all-ones time. `fb_cmd` 011 (all-bank refresh) wakes it, returns it to regular, and sets the trigger to the sampled counter value plus one interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_idle | input | N_BANKS | Per-bank flag: no pending traffic |
| bank_active | input | N_BANKS | Per-bank flag: a row is open |
| fb_cmd | input | 3 | Command the controller sent this cycle (000 none) |
| req_cmd | output | 2 | Requested command: 00 none, 01 precharge, 10 per-bank refresh |
| req_bank | output | BANK_W | Target bank of the request |
| bank_blocked | output | N_BANKS | One-hot hold-off for a forced refresh |
| pd_wake_req | output | 1 | One-cycle request to leave power-down |

## Verification
The hardest condition to reach from the ports is the overdue catch-up of R9. It needs the block to sit in the pulled-in state with a request outstanding until a whole extra interval has passed. Its only visible trace is a change in how many pulled-in refreshes follow. The stimulus refreshes bank 0 on schedule, lets the pulled-in request for bank 1 wait past twice the interval, and then counts the burst. The credit was not lowered for bank 1, so four more refreshes follow instead of three. The forced path of R6 is reached by holding every bank busy for five intervals, with bank 0 left open so that the precharge step appears first.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'b00,
        REQ_PRE   = 2'b01,
        REQ_REFPB = 2'b10
    } req_cmd_e;

    typedef enum logic [2:0] {
        FB_NONE     = 3'b000,
        FB_PRE      = 3'b001,
        FB_REFPB    = 3'b010,
        FB_REFAB    = 3'b011,
        FB_PD_ENTER = 3'b100,
        FB_PD_EXIT  = 3'b101,
        FB_SR_ENTER = 3'b110
    } fb_cmd_e;

    typedef enum logic {
        ST_REGULAR = 1'b0,
        ST_PULLED  = 1'b1
    } sched_state_e;

    function automatic int bank_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/refsched_timebase.sv
module refsched_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end

    a_r1_time_steps: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> now == $past(now) + 1'b1);

endmodule

// File: rtl/refsched_bank_pick.sv
module refsched_bank_pick #(
    parameter int N_BANKS = 8,
    parameter int BANK_W  = 3
) (
    input  logic [N_BANKS-1:0] remaining,
    input  logic [N_BANKS-1:0] idle,
    output logic               any_idle,
    output logic [BANK_W-1:0]  idle_idx,
    output logic [BANK_W-1:0]  first_idx
);

    always_comb begin
        any_idle  = 1'b0;
        idle_idx  = '0;
        first_idx = '0;
        for (int i = N_BANKS - 1; i >= 0; i--) begin
            if (remaining[i]) first_idx = BANK_W'(i);
            if (remaining[i] && idle[i]) begin
                any_idle = 1'b1;
                idle_idx = BANK_W'(i);
            end
        end
    end

endmodule

// File: rtl/refsched_round.sv
module refsched_round #(
    parameter int N_BANKS = 8,
    parameter int BANK_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               retire,
    input  logic [BANK_W-1:0]  retire_bank,
    output logic [N_BANKS-1:0] remaining
);

    logic [N_BANKS-1:0] retire_mask;
    logic [N_BANKS-1:0] left_over;

    generate
        for (genvar g = 0; g < N_BANKS; g++) begin : g_mask
            assign retire_mask[g] = (retire_bank == BANK_W'(g));
        end
    endgenerate

    assign left_over = remaining & ~retire_mask;

    always_ff @(posedge clk) begin
        if (rst)                        remaining <= '1;
        else if (retire && left_over == '0) remaining <= '1;
        else if (retire)                remaining <= left_over;
    end

    a_r4_round_never_empty: assert property (@(posedge clk) disable iff (rst)
        remaining != '0);

    a_r4_retire_clears_bit: assert property (@(posedge clk) disable iff (rst)
        (retire && left_over != '0) |=> remaining[$past(retire_bank)] == 1'b0);

endmodule

// File: rtl/refsched_top.sv
module refsched_top
    import refsched_pkg::*;
#(
    parameter int N_BANKS      = 8,
    parameter int TIME_W       = 32,
    parameter int REF_INTERVAL = 3900,
    parameter int MAX_POSTPONE = 8,
    parameter int MAX_PULLIN   = 8,
    localparam int BANK_W      = bank_width(N_BANKS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_BANKS-1:0] bank_idle,
    input  logic [N_BANKS-1:0] bank_active,
    input  logic [2:0]         fb_cmd,
    output logic [1:0]         req_cmd,
    output logic [BANK_W-1:0]  req_bank,
    output logic [N_BANKS-1:0] bank_blocked,
    output logic               pd_wake_req
);

    localparam int POST_LIM = MAX_POSTPONE * N_BANKS;
    localparam int PULL_ABS = MAX_PULLIN * N_BANKS;
    localparam int CW       = $clog2(POST_LIM + PULL_ABS + 1) + 2;
    localparam logic signed [CW-1:0] POST_C = CW'(POST_LIM);
    localparam logic signed [CW-1:0] PULL_C = -CW'(PULL_ABS);
    localparam logic signed [CW-1:0] ONE_C  = CW'(1);
    localparam logic [TIME_W-1:0]    IVL    = TIME_W'(REF_INTERVAL);

    logic [TIME_W-1:0]        now;
    logic [TIME_W-1:0]        trigger;
    sched_state_e             state;
    logic signed [CW-1:0]     credit;
    logic                     sleeping;
    req_cmd_e                 req_q;
    logic [BANK_W-1:0]        bank_q;
    logic [N_BANKS-1:0]       block_q;
    logic                     due_q;
    logic                     wake_q;

    logic [N_BANKS-1:0]       remaining;
    logic                     any_idle;
    logic [BANK_W-1:0]        idle_idx;
    logic [BANK_W-1:0]        first_idx;

    fb_cmd_e                  fb;
    logic                     due;
    logic                     overdue;
    sched_state_e             ev_state;
    logic [TIME_W-1:0]        ev_trigger;
    logic                     forced;
    logic [BANK_W-1:0]        tgt;
    logic [N_BANKS-1:0]       tgt_onehot;
    logic signed [CW-1:0]     credit_after;
    logic                     refpb_done;

    refsched_timebase #(.TIME_W(TIME_W)) u_timebase (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    refsched_round #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_round (
        .clk         (clk),
        .rst         (rst),
        .retire      (refpb_done),
        .retire_bank (bank_q),
        .remaining   (remaining)
    );

    refsched_bank_pick #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_pick (
        .remaining (remaining),
        .idle      (bank_idle),
        .any_idle  (any_idle),
        .idle_idx  (idle_idx),
        .first_idx (first_idx)
    );

    always_comb begin
        fb           = fb_cmd_e'(fb_cmd);
        refpb_done   = (fb == FB_REFPB);
        due          = (now >= trigger);
        overdue      = due && ((now - trigger) >= IVL);
        ev_state     = overdue ? ST_REGULAR : state;
        ev_trigger   = overdue ? trigger + IVL : trigger;
        forced       = (credit == POST_C);
        tgt          = any_idle ? idle_idx : first_idx;
        tgt_onehot   = '0;
        tgt_onehot[tgt] = 1'b1;
        credit_after = (state == ST_PULLED) ? credit - ONE_C : credit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trigger  <= IVL;
            state    <= ST_REGULAR;
            credit   <= '0;
            sleeping <= 1'b0;
            req_q    <= REQ_NONE;
            bank_q   <= '0;
            block_q  <= '0;
            due_q    <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            due_q  <= due;
            wake_q <= due && !due_q;
            case (fb)
                FB_PD_ENTER: begin
                    sleeping <= 1'b1;
                    req_q    <= REQ_NONE;
                    block_q  <= '0;
                end
                FB_SR_ENTER: begin
                    sleeping <= 1'b1;
                    trigger  <= '1;
                    req_q    <= REQ_NONE;
                    block_q  <= '0;
                end
                FB_PD_EXIT: sleeping <= 1'b0;
                FB_REFAB: begin
                    sleeping <= 1'b0;
                    state    <= ST_REGULAR;
                    trigger  <= now + IVL;
                end
                FB_PRE: req_q <= REQ_NONE;
                FB_REFPB: begin
                    req_q   <= REQ_NONE;
                    block_q <= '0;
                    credit  <= credit_after;
                    if (credit_after == PULL_C) begin
                        state   <= ST_REGULAR;
                        trigger <= trigger + IVL;
                    end else begin
                        state   <= ST_PULLED;
                    end
                end
                default: begin
                    if (!sleeping && due) begin
                        state   <= ev_state;
                        trigger <= ev_trigger;
                        if (req_q == REQ_NONE) begin
                            if (ev_state == ST_REGULAR) begin
                                if (!any_idle && !forced) begin
                                    credit  <= credit + ONE_C;
                                    trigger <= ev_trigger + IVL;
                                end else begin
                                    bank_q <= tgt;
                                    if (bank_active[tgt]) begin
                                        req_q <= REQ_PRE;
                                    end else begin
                                        req_q   <= REQ_REFPB;
                                        block_q <= forced ? tgt_onehot : '0;
                                    end
                                end
                            end else if (!any_idle) begin
                                state   <= ST_REGULAR;
                                trigger <= ev_trigger + IVL;
                            end else begin
                                bank_q <= idle_idx;
                                req_q  <= bank_active[idle_idx] ? REQ_PRE : REQ_REFPB;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign req_cmd      = req_q;
    assign req_bank     = bank_q;
    assign bank_blocked = block_q;
    assign pd_wake_req  = wake_q;

    a_r6_block_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_blocked));

    a_r6_block_with_refresh: assert property (@(posedge clk) disable iff (rst)
        (bank_blocked != '0) |-> (req_cmd == REQ_REFPB) && bank_blocked[req_bank]);

    a_r10_request_held: assert property (@(posedge clk) disable iff (rst)
        (req_cmd != REQ_NONE && fb_cmd == FB_NONE) |=>
            $stable(req_cmd) && $stable(req_bank));

    a_r2_wake_single: assert property (@(posedge clk) disable iff (rst)
        pd_wake_req |=> !pd_wake_req);

    a_r5_credit_window: assert property (@(posedge clk) disable iff (rst)
        (credit <= POST_C) && (credit >= PULL_C));

    a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        sleeping |-> req_cmd == REQ_NONE);

    a_r3_target_remaining: assert property (@(posedge clk) disable iff (rst)
        (req_cmd != REQ_NONE) |-> remaining[req_bank]);

endmodule

// File: tb/refsched_top_bench.sv
module refsched_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int IV  = 20;
    localparam int BW  = 2;
    localparam int NV  = 6;

    localparam logic [NB-1:0] V_IDLE [NV] = '{4'b1111, 4'b0100, 4'b1000, 4'b0110, 4'b0000, 4'b1010};
    localparam logic [NB-1:0] V_ACT  [NV] = '{4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b1010};
    localparam int            V_CMD  [NV] = '{2, 2, 2, 1, 0, 1};
    localparam int            V_BANK [NV] = '{0, 2, 3, 1, 0, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] bank_idle = '0;
    logic [NB-1:0] bank_active = '0;
    logic [2:0]    fb_cmd = '0;
    logic [1:0]    req_cmd;
    logic [BW-1:0] req_bank;
    logic [NB-1:0] bank_blocked;
    logic          pd_wake_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    refsched_top #(
        .N_BANKS(NB), .TIME_W(16), .REF_INTERVAL(IV),
        .MAX_POSTPONE(1), .MAX_PULLIN(1)
    ) u_refsched_top (
        .clk(clk), .rst(rst), .bank_idle(bank_idle), .bank_active(bank_active),
        .fb_cmd(fb_cmd), .req_cmd(req_cmd), .req_bank(req_bank),
        .bank_blocked(bank_blocked), .pd_wake_req(pd_wake_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fb_cmd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] code);
        fb_cmd = code;
        @(posedge clk);
        @(negedge clk);
        fb_cmd = '0;
    endtask

    task automatic wait_req(input int maxc, output bit found);
        found = (req_cmd != 2'b00);
        for (int k = 0; k < maxc && !found; k++) begin
            @(negedge clk);
            found = (req_cmd != 2'b00);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit found;
        int seq [4];

        // R1 reset state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_eq("R1 reset req_cmd", req_cmd, 0);
        chk_eq("R1 reset blocked", bank_blocked, 0);
        chk_eq("R1 reset wake", pd_wake_req, 0);

        // Table: selection at the first due point (R1, R2, R3, R5)
        for (int i = 0; i < NV; i++) begin
            bank_idle = V_IDLE[i];
            bank_active = V_ACT[i];
            do_reset();
            wait_cyc(IV);
            chk_eq("R1 no request before interval", req_cmd, 0);
            wait_cyc(IV + 1);
            chk_eq("R3 command", req_cmd, V_CMD[i]);
            if (V_CMD[i] != 0) chk_eq("R3 target bank", req_bank, V_BANK[i]);
            chk_eq("R2 wake pulse", pd_wake_req, 1);
            chk_eq("R6 no block unforced", bank_blocked, 0);
        end

        // Postpone then forced refresh (R5, R6, R8, R10, R2)
        bank_idle = 4'b0000;
        bank_active = 4'b0001;
        do_reset();
        wait_cyc(IV + 1);
        chk_eq("R5 postponed", req_cmd, 0);
        wait_cyc(IV + 2);
        chk_eq("R2 wake one cycle", pd_wake_req, 0);
        wait_cyc(2*IV + 1);
        chk_eq("R5 trigger advanced", pd_wake_req, 1);
        wait_cyc(5*IV);
        chk_eq("R5 still postponed", req_cmd, 0);
        wait_cyc(5*IV + 1);
        chk_eq("R6 forced precharge", req_cmd, 1);
        chk_eq("R6 forced bank", req_bank, 0);
        chk_eq("R6 no block on precharge", bank_blocked, 0);
        bank_active = 4'b0000;
        issue(3'b001);
        chk_eq("R10 precharge clears", req_cmd, 0);
        wait_cyc(5*IV + 3);
        chk_eq("R6 forced refresh", req_cmd, 2);
        chk_eq("R6 forced refresh bank", req_bank, 0);
        chk_eq("R6 block set", bank_blocked, 1);
        issue(3'b010);
        chk_eq("R6 block released", bank_blocked, 0);
        wait_cyc(6*IV);
        chk_eq("R8 back to regular wait", req_cmd, 0);
        wait_cyc(6*IV + 1);
        chk_eq("R8 next forced refresh", req_cmd, 2);
        chk_eq("R4 rotation to bank 1", req_bank, 1);
        chk_eq("R6 block bank 1", bank_blocked, 2);

        // Pull-in burst and refill (R7, R4)
        bank_idle = 4'b1111;
        bank_active = 4'b0000;
        do_reset();
        wait_cyc(IV + 1);
        chk_eq("R7 first refresh", req_cmd, 2);
        issue(3'b010);
        seq = '{1, 2, 3, 0};
        for (int k = 0; k < 4; k++) begin
            wait_req(6, found);
            chk_eq("R7 pulled-in request", req_cmd, 2);
            chk_eq("R4 pulled-in bank", req_bank, seq[k]);
            issue(3'b010);
        end
        wait_req(6, found);
        chk_eq("R7 stop at pull-in limit", found, 0);
        wait_cyc(2*IV + 1);
        chk_eq("R4 refill resumes at bank 1", req_bank, 1);
        chk_eq("R7 next regular refresh", req_cmd, 2);

        // Overdue catch-up (R9, R10)
        do_reset();
        wait_cyc(IV + 1);
        issue(3'b010);
        wait_req(6, found);
        chk_eq("R7 bank 1 pulled in", req_bank, 1);
        wait_cyc(2*IV + 2);
        chk_eq("R10 request held", req_cmd, 2);
        chk_eq("R10 bank held", req_bank, 1);
        issue(3'b010);
        seq = '{2, 3, 0, 1};
        for (int k = 0; k < 4; k++) begin
            wait_req(6, found);
            chk_eq("R9 burst length", found, 1);
            chk_eq("R9 burst bank", req_bank, seq[k]);
            issue(3'b010);
        end
        wait_req(6, found);
        chk_eq("R9 burst ends", found, 0);

        // Power-down (R11, R2)
        do_reset();
        wait_cyc(5);
        issue(3'b100);
        wait_cyc(IV + 1);
        chk_eq("R11 asleep no request", req_cmd, 0);
        chk_eq("R2 wake while asleep", pd_wake_req, 1);
        wait_cyc(IV + 10);
        chk_eq("R11 still asleep", req_cmd, 0);
        issue(3'b101);
        wait_req(3, found);
        chk_eq("R11 request after exit", req_cmd, 2);
        chk_eq("R11 bank after exit", req_bank, 0);

        // Self-refresh (R12)
        do_reset();
        wait_cyc(5);
        issue(3'b110);
        wait_cyc(3*IV);
        chk_eq("R12 parked no request", req_cmd, 0);
        chk_eq("R12 parked no wake", pd_wake_req, 0);
        issue(3'b011);
        wait_cyc(4*IV);
        chk_eq("R12 waits one interval", req_cmd, 0);
        wait_cyc(4*IV + 1);
        chk_eq("R12 refresh after interval", req_cmd, 2);
        chk_eq("R12 wake pulse", pd_wake_req, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule